// File: doc/BRIEF.md
# Maskable Interrupt Logic for a Token-Passing Network Controller

This block gathers the interrupt-capable status conditions of a token-passing network controller, gates them with a host-written mask, and drives one registered interrupt request line. Five conditions can interrupt. Two are live levels from the transmit and receive logic: transmitter available and receiver inhibited. Three are sticky flags, each set by a one-cycle event pulse: reconfiguration timeout, excessive NAK and new next-node ID.

The host sets the 8-bit mask with a single-cycle write strobe. Each sticky flag has its own way to clear. The ordinary clear-flags command clears the reconfiguration flag. The power-on clear-flags command clears the excessive-NAK flag. A host read of the next-node-ID register clears the new-next-ID flag. The status byte and the mask byte are visible at all times on plain output pins. There is no data stream here, so every pin is a plain control or status signal and there is no valid/ready handshake.

Top module: `nic_irq_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `mask_o` is 8'h00, the three sticky flags are 0 and `irq_o` is 0.
- R2: A cycle with `mask_wr` high loads `mask_o` with `mask_wdata & 8'h8F` at the next clock edge. Bits 6 to 4 of `mask_o` always read 0, and without `mask_wr` the mask holds.
- R3: `status_o` uses this layout: bit 7 receiver inhibited, bit 3 excessive NAK, bit 2 reconfiguration, bit 1 new next ID, bit 0 transmitter available, and bits 6 to 4 always 0. Bits 7 and 0 follow `rx_inhib_i` and `tx_avail_i` in the same cycle.
- R4: An event pulse (`ev_recon_i`, `ev_excnak_i`, `ev_newnid_i`) sets its flag at the next edge. The flag then stays 1 until its own clear action.
- R5: The reconfiguration flag is cleared by `cmd_clr_flags_i` and by nothing else.
- R6: The excessive-NAK flag is cleared by `cmd_por_clr_i` and by nothing else.
- R7: The new-next-ID flag is cleared by `nid_rd_i` and by nothing else.
- R8: If a flag's event and its clear fall in the same cycle, the flag is 1 after the edge.
- R9: At each edge, `irq_o` takes the value of the OR over all bits of (`status_o` & `mask_o`) as it was just before that edge.
- R10: Masking receiver inhibited or transmitter available only hides it. If the level is still high when the mask bit is set again, `irq_o` rises again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wr | input | 1 | Single-cycle mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| cmd_clr_flags_i | input | 1 | Ordinary clear-flags command pulse |
| cmd_por_clr_i | input | 1 | Power-on clear-flags command pulse |
| nid_rd_i | input | 1 | Host read of the next-node-ID register |
| ev_recon_i | input | 1 | Reconfiguration timeout event pulse |
| ev_excnak_i | input | 1 | Excessive NAK event pulse |
| ev_newnid_i | input | 1 | New next-node-ID event pulse |
| rx_inhib_i | input | 1 | Receiver inhibited level |
| tx_avail_i | input | 1 | Transmitter available level |
| status_o | output | 8 | Status byte |
| mask_o | output | 8 | Mask byte |
| irq_o | output | 1 | Registered active-high interrupt request |

## Verification
The hardest case to reach is a flag whose event and clear land in the same cycle while other commands arrive that must leave it alone. The stimulus first sets all three sticky flags. It then issues each clear that belongs to some other flag, issues each flag's own clear, and finally pairs every event with its own clear in one cycle. The unmask-while-still-high case for the two level bits is reached by toggling their mask bits while the levels are held high. A long run of random pulses, levels and mask writes follows, and a behavioural model is compared against the outputs on every clock.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int STAT_W     = 8;
  localparam int BIT_TXAV   = 0;
  localparam int BIT_NEWNID = 1;
  localparam int BIT_RECON  = 2;
  localparam int BIT_EXCNAK = 3;
  localparam int BIT_RXINH  = 7;
  localparam int N_STICKY   = 3;
  localparam logic [STAT_W-1:0] IMPL_BITS =
    (STAT_W'(1) << BIT_TXAV) | (STAT_W'(1) << BIT_NEWNID) |
    (STAT_W'(1) << BIT_RECON) | (STAT_W'(1) << BIT_EXCNAK) |
    (STAT_W'(1) << BIT_RXINH);
endpackage

// File: rtl/nic_sticky_flags.sv
module nic_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (set_i[g]) flag_q <= 1'b1;   // set has priority
      else if (clr_i[g]) flag_q <= 1'b0;
    end
    assign flag_o[g] = flag_q;

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_q);                                   // R8
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flag_q);                   // R5
    AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i[g]) |=> flag_q);                      // R4
  end
endmodule

// File: rtl/nic_mask_reg.sv
module nic_mask_reg #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i & KEEP;
  end
  assign mask_o = mask_q;

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_q == ($past(wdata_i) & KEEP)));            // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q));                               // R2
endmodule

// File: rtl/nic_irq_gen.sv
module nic_irq_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_i & mask_i);
  end
  assign irq_o = irq_q;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i & mask_i) == '0) |=> !irq_q);                  // R9
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i & mask_i) != '0) |=> irq_q);                   // R9
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [STAT_W-1:0] mask_wdata,
  input  logic              cmd_clr_flags_i,
  input  logic              cmd_por_clr_i,
  input  logic              nid_rd_i,
  input  logic              ev_recon_i,
  input  logic              ev_excnak_i,
  input  logic              ev_newnid_i,
  input  logic              rx_inhib_i,
  input  logic              tx_avail_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_o
);
  // sticky slot order: 0 new next ID, 1 reconfiguration, 2 excessive NAK
  logic [N_STICKY-1:0] sticky_set, sticky_clr, sticky_q;

  assign sticky_set = {ev_excnak_i, ev_recon_i, ev_newnid_i};
  assign sticky_clr = {cmd_por_clr_i, cmd_clr_flags_i, nid_rd_i};

  nic_sticky_flags #(.N(N_STICKY)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (sticky_set),
    .clr_i  (sticky_clr),
    .flag_o (sticky_q)
  );

  nic_mask_reg #(.W(STAT_W), .KEEP(IMPL_BITS)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_wr),
    .wdata_i (mask_wdata),
    .mask_o  (mask_o)
  );

  always_comb begin
    status_o             = '0;
    status_o[BIT_TXAV]   = tx_avail_i;
    status_o[BIT_NEWNID] = sticky_q[0];
    status_o[BIT_RECON]  = sticky_q[1];
    status_o[BIT_EXCNAK] = sticky_q[2];
    status_o[BIT_RXINH]  = rx_inhib_i;
  end

  nic_irq_gen #(.W(STAT_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_o),
    .mask_i   (mask_o),
    .irq_o    (irq_o)
  );

  AST_LEVEL_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_inhib_i && mask_o[BIT_RXINH]) |=> irq_o);             // R10
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> ((mask_o & ~IMPL_BITS) == '0));               // R2
endmodule

// File: tb/nic_irq_ctrl_tb_top.sv
module nic_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mask_wr = 1'b0;
  logic [7:0] mask_wdata = 8'h00;
  logic cmd_clr_flags_i = 1'b0, cmd_por_clr_i = 1'b0, nid_rd_i = 1'b0;
  logic ev_recon_i = 1'b0, ev_excnak_i = 1'b0, ev_newnid_i = 1'b0;
  logic rx_inhib_i = 1'b0, tx_avail_i = 1'b0;
  logic [7:0] status_o, mask_o;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_mask = 0;
  int m_recon = 0, m_exc = 0, m_nid = 0;
  int m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .cmd_clr_flags_i(cmd_clr_flags_i), .cmd_por_clr_i(cmd_por_clr_i),
    .nid_rd_i(nid_rd_i), .ev_recon_i(ev_recon_i), .ev_excnak_i(ev_excnak_i),
    .ev_newnid_i(ev_newnid_i), .rx_inhib_i(rx_inhib_i), .tx_avail_i(tx_avail_i),
    .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  function automatic int model_status();
    return (rx_inhib_i ? 128 : 0) + m_exc * 8 + m_recon * 4 + m_nid * 2 +
           (tx_avail_i ? 1 : 0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // advance one clock: update model at the edge, compare at the falling edge
  task automatic tick();
    int st;
    @(posedge clk);
    st = model_status();
    if (!rst_n) begin
      m_mask = 0; m_recon = 0; m_exc = 0; m_nid = 0; m_irq = 0;
    end else begin
      m_irq = ((st % 256) & m_mask) != 0 ? 1 : 0;
      if (mask_wr) m_mask = mask_wdata & 8'h8F;
      if (ev_recon_i) m_recon = 1; else if (cmd_clr_flags_i) m_recon = 0;
      if (ev_excnak_i) m_exc = 1; else if (cmd_por_clr_i) m_exc = 0;
      if (ev_newnid_i) m_nid = 1; else if (nid_rd_i) m_nid = 0;
    end
    @(negedge clk);
    if (!rst_n) check("R1 reset", {mask_o, 7'b0, irq_o}, 0);
    check("R2 mask", mask_o, m_mask);
    check("R3 R4 R5 R6 R7 R8 status", status_o, model_status());
    check("R9 R10 irq", irq_o, m_irq);
    mask_wr = 0; cmd_clr_flags_i = 0; cmd_por_clr_i = 0; nid_rd_i = 0;
    ev_recon_i = 0; ev_excnak_i = 0; ev_newnid_i = 0;
  endtask

  task automatic wmask(input logic [7:0] v);
    mask_wr = 1; mask_wdata = v; tick();
  endtask

  initial begin
    @(negedge clk);
    // R1: outputs held at reset values, even with stimulus present
    mask_wr = 1; mask_wdata = 8'hFF; ev_recon_i = 1;
    tick(); tick();
    rst_n = 1; tick();
    // R2: unused bits dropped
    wmask(8'hFF); tick();
    wmask(8'h70); tick();
    // R3 R10: receiver inhibited level, mask toggle while held
    wmask(8'h80); rx_inhib_i = 1; tick(); tick();
    wmask(8'h00); tick(); tick();
    wmask(8'h80); tick(); tick();
    rx_inhib_i = 0; tick(); tick();
    // R10: transmitter available
    wmask(8'h01); tx_avail_i = 1; tick();
    wmask(8'h00); tick();
    wmask(8'h01); tick(); tick();
    tx_avail_i = 0; tick();
    // R4: set all sticky flags, mask them all
    wmask(8'h0E);
    ev_recon_i = 1; ev_excnak_i = 1; ev_newnid_i = 1; tick(); tick();
    // R5 R6 R7: wrong clears have no effect on the other flags
    cmd_clr_flags_i = 1; tick();            // clears only reconfiguration
    ev_recon_i = 1; tick();
    nid_rd_i = 1; tick();                   // clears only new next ID
    ev_newnid_i = 1; tick();
    cmd_por_clr_i = 1; tick();              // clears only excessive NAK
    tick();
    cmd_clr_flags_i = 1; nid_rd_i = 1; tick();
    // R8: set and own clear together
    ev_recon_i = 1; cmd_clr_flags_i = 1; tick();
    ev_excnak_i = 1; cmd_por_clr_i = 1; tick();
    ev_newnid_i = 1; nid_rd_i = 1; tick(); tick();
    // R9: all flags set, mask zero, no interrupt
    wmask(8'h00); tick();
    wmask(8'h04); tick();
    // random run
    for (int i = 0; i < 600; i++) begin
      int r = $urandom;
      mask_wr = (r[3:0] == 0); mask_wdata = 8'($urandom);
      cmd_clr_flags_i = (r[7:4] == 1); cmd_por_clr_i = (r[7:4] == 2);
      nid_rd_i = (r[7:4] == 3);
      ev_recon_i = (r[11:8] == 1); ev_excnak_i = (r[11:8] == 2) || (r[15:12] == 5);
      ev_newnid_i = (r[11:8] == 3) || (r[7:4] == 3 && r[16]);
      if (r[20:18] == 0) rx_inhib_i = ~rx_inhib_i;
      if (r[23:21] == 0) tx_avail_i = ~tx_avail_i;
      tick();
    end
    // R1: reset mid-run
    ev_excnak_i = 1; tick();
    rst_n = 0; tick(); rst_n = 1; tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule